// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over many clock cycles and returns the full 64-bit product as two separate words. The high word holds the upper half and the low word holds the lower half. A one-cycle start pulse loads both operands and a mode select that picks signed or unsigned arithmetic. The block then runs one partial-product step per clock. Each step adds the multiplicand into the upper half of a running product when the current multiplier bit is set, and shifts the whole running product right by one place in the same cycle.

For signed work, the operands are first reduced to their magnitudes. Their product is formed as an unsigned value and negated when the operand signs differ. When the result is written out, an overflow flag also reports whether the product needs more than 32 bits. In unsigned mode this means any high-word bit is set. In signed mode it means the high word is not a copy of bit 31 of the low word.

While a multiply runs, busy stays high and further start pulses are ignored. The results stay on the outputs until the next multiply completes.

Top module: `seq_mult`

## Requirements
- R1: After reset, busy, done, ovf, hi and lo are all 0.
- R2: A start accepted at a clock edge makes done high for exactly one cycle, and that cycle begins 34 edges later (one setup edge, 32 step edges, one finish edge).
- R3: With is_signed = 0, {hi, lo} equals the unsigned 64-bit product of op_a and op_b, with hi holding bits 63..32.
- R4: With is_signed = 1, {hi, lo} equals the two's-complement 64-bit product of the signed operands, including the most negative operand value.
- R5: In unsigned mode, ovf is 1 exactly when hi is nonzero.
- R6: In signed mode, ovf is 1 exactly when hi differs from 32 copies of lo bit 31.
- R7: A start, or any change of op_a, op_b or is_signed, while busy is high does not change the result or the timing of the multiply in progress.
- R8: busy rises on the edge that accepts a start, stays high through the cycle in which done is high, and is low in the next cycle.
- R9: hi, lo and ovf change only on the edge that raises done, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiply; taken only while busy is low |
| is_signed | input | 1 | 1 selects two's-complement operands, 0 selects unsigned |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| busy | output | 1 | High while a multiply is in progress, up to and including the done cycle |
| done | output | 1 | One-cycle pulse when new results are present |
| hi | output | 32 | Upper word of the product |
| lo | output | 32 | Lower word of the product |
| ovf | output | 1 | Product does not fit in 32 bits for the selected mode |

## Verification
The checker assumes that a start is taken only while busy is low. It also assumes that the mode latched when a start is accepted is the mode that applies to the next done cycle. The checker tracks that mode itself from the start and is_signed ports.

The bench drives every input on the falling edge and raises start only once the previous done has cleared. When it issues starts or changes the operands during a run, it does so only while busy is high, which is exactly the case the requirements say must be ignored.

// File: rtl/mul_pkg.sv
package mul_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_STEP   = 3'd2,
      ST_FINISH = 3'd3,
      ST_DONE   = 3'd4
   } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
   import mul_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic init,
   output logic step,
   output logic finish,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(WIDTH) + 1;
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   mul_state_e state_q, state_d;
   logic [CW-1:0] cnt_q;

   assign accept = (state_q == ST_IDLE) && start;
   assign init   = (state_q == ST_SETUP);
   assign step   = (state_q == ST_STEP);
   assign finish = (state_q == ST_FINISH);
   assign busy   = (state_q != ST_IDLE);
   assign done   = (state_q == ST_DONE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start) state_d = ST_SETUP;
         ST_SETUP:  state_d = ST_STEP;
         ST_STEP:   if (cnt_q == LAST) state_d = ST_FINISH;
         ST_FINISH: state_d = ST_DONE;
         ST_DONE:   state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (init)      cnt_q <= '0;
         else if (step) cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mul_sign_prep.sv
module mul_sign_prep #(
   parameter int WIDTH        = 32,
   parameter bit ALLOW_SIGNED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             is_signed,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic [WIDTH-1:0] mag_a,
   output logic [WIDTH-1:0] mag_b,
   output logic             negate,
   output logic             sgn_mode
);
   logic [WIDTH-1:0] abs_a, abs_b;
   logic             neg_d, mode_d;

   generate
      if (ALLOW_SIGNED) begin : g_signed
         assign mode_d = is_signed;
         assign abs_a  = (is_signed && op_a[WIDTH-1]) ? (~op_a + 1'b1) : op_a;
         assign abs_b  = (is_signed && op_b[WIDTH-1]) ? (~op_b + 1'b1) : op_b;
         assign neg_d  = is_signed && (op_a[WIDTH-1] ^ op_b[WIDTH-1]);
      end else begin : g_unsigned
         logic unused_mode;
         assign unused_mode = is_signed;
         assign mode_d = 1'b0;
         assign abs_a  = op_a;
         assign abs_b  = op_b;
         assign neg_d  = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag_a    <= '0;
         mag_b    <= '0;
         negate   <= 1'b0;
         sgn_mode <= 1'b0;
      end else if (accept) begin
         mag_a    <= abs_a;
         mag_b    <= abs_b;
         negate   <= neg_d;
         sgn_mode <= mode_d;
      end
   end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
   parameter int WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init,
   input  logic               step,
   input  logic [WIDTH-1:0]   mag_a,
   input  logic [WIDTH-1:0]   mag_b,
   output logic [2*WIDTH-1:0] prod
);
   localparam int PW = 2 * WIDTH;

   logic [WIDTH-1:0] mcand_q;
   logic [PW-1:0]    prod_q;
   logic [WIDTH:0]   upper_sum;

   assign upper_sum = {1'b0, prod_q[PW-1:WIDTH]}
                    + {1'b0, (prod_q[0] ? mcand_q : {WIDTH{1'b0}})};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         prod_q  <= '0;
      end else if (init) begin
         mcand_q <= mag_a;
         prod_q  <= {{WIDTH{1'b0}}, mag_b};
      end else if (step) begin
         prod_q  <= {upper_sum, prod_q[WIDTH-1:1]};
      end
   end

   assign prod = prod_q;
endmodule

// File: rtl/mul_result.sv
module mul_result #(
   parameter int WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               finish,
   input  logic               negate,
   input  logic               sgn_mode,
   input  logic [2*WIDTH-1:0] prod,
   output logic [WIDTH-1:0]   hi,
   output logic [WIDTH-1:0]   lo,
   output logic               ovf
);
   localparam int PW = 2 * WIDTH;

   logic [PW-1:0]    fixed;
   logic [WIDTH-1:0] hi_d, lo_d;
   logic             ovf_d;

   assign fixed = negate ? (~prod + 1'b1) : prod;
   assign hi_d  = fixed[PW-1:WIDTH];
   assign lo_d  = fixed[WIDTH-1:0];
   assign ovf_d = sgn_mode ? (hi_d != {WIDTH{lo_d[WIDTH-1]}})
                           : (hi_d != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi  <= '0;
         lo  <= '0;
         ovf <= 1'b0;
      end else if (finish) begin
         hi  <= hi_d;
         lo  <= lo_d;
         ovf <= ovf_d;
      end
   end
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
   parameter int WIDTH        = 32,
   parameter bit ALLOW_SIGNED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_signed,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] hi,
   output logic [WIDTH-1:0] lo,
   output logic             ovf
);
   localparam int PW = 2 * WIDTH;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seq_mult: WIDTH must be at least 2");
      end
   endgenerate

   logic             accept, init, step, finish;
   logic [WIDTH-1:0] mag_a, mag_b;
   logic             negate, sgn_mode;
   logic [PW-1:0]    prod;

   mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .accept(accept), .init(init), .step(step), .finish(finish),
      .busy(busy), .done(done)
   );

   mul_sign_prep #(.WIDTH(WIDTH), .ALLOW_SIGNED(ALLOW_SIGNED)) u_prep (
      .clk(clk), .rst_n(rst_n), .accept(accept), .is_signed(is_signed),
      .op_a(op_a), .op_b(op_b), .mag_a(mag_a), .mag_b(mag_b),
      .negate(negate), .sgn_mode(sgn_mode)
   );

   mul_datapath #(.WIDTH(WIDTH)) u_dp (
      .clk(clk), .rst_n(rst_n), .init(init), .step(step),
      .mag_a(mag_a), .mag_b(mag_b), .prod(prod)
   );

   mul_result #(.WIDTH(WIDTH)) u_res (
      .clk(clk), .rst_n(rst_n), .finish(finish), .negate(negate),
      .sgn_mode(sgn_mode), .prod(prod), .hi(hi), .lo(lo), .ovf(ovf)
   );
endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             is_signed,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] hi,
   input logic [WIDTH-1:0] lo,
   input logic             ovf
);
   localparam int LAT = WIDTH + 2;
   localparam int TW  = $clog2(LAT + 2) + 1;

   logic          mode_q;
   logic [TW-1:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         since_q <= '0;
      end else if (start && !busy) begin
         mode_q  <= is_signed;
         since_q <= '0;
      end else if (busy) begin
         since_q <= since_q + 1'b1;
      end
   end

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (since_q == TW'(LAT)));
   p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   p_busy_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({hi, lo, ovf}) |-> done);
   p_ovf_unsigned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mode_q) |-> (ovf == (hi != '0)));
   p_ovf_signed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_q) |-> (ovf == (hi != {WIDTH{lo[WIDTH-1]}})));
endmodule

bind seq_mult mul_chk #(.WIDTH(WIDTH)) u_mul_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
   .busy(busy), .done(done), .hi(hi), .lo(lo), .ovf(ovf)
);

// File: tb/tb_seq_mult.sv
module tb_seq_mult;
   localparam int  W      = 32;
   localparam time CLK_P  = 10ns;
   localparam int  LAT    = W + 2;

   logic clk = 1'b0;
   logic rst_n, start, is_signed;
   logic [W-1:0] op_a, op_b;
   logic busy, done, ovf;
   logic [W-1:0] hi, lo;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   seq_mult #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
      .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
      .hi(hi), .lo(lo), .ovf(ovf)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
      logic signed [63:0] sa, sb;
      if (s) begin
         sa = $signed({{W{a[W-1]}}, a});
         sb = $signed({{W{b[W-1]}}, b});
         return sa * sb;
      end
      return {32'b0, a} * {32'b0, b};
   endfunction

   function automatic logic model_ovf(input logic [63:0] p, input logic s);
      if (s) return p[63:32] != {32{p[31]}};
      return p[63:32] != 32'b0;
   endfunction

   // Start a multiply; optionally disturb the inputs mid-run (R7).
   task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                          input string req, input bit disturb);
      logic [63:0] exp;
      int n;
      exp = model(a, b, s);
      @(negedge clk);
      op_a = a; op_b = b; is_signed = s; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R8 busy after accept", {63'b0, busy}, 64'd1);
      n = 0;
      while (!done && n < 2*LAT) begin
         @(negedge clk);
         n++;
         if (disturb && n == 10) begin
            start = 1'b1; op_a = ~a; op_b = a ^ b; is_signed = ~s;
         end
         if (disturb && n == 11) start = 1'b0;
      end
      check({req, " product"}, {hi, lo}, exp);
      check(s ? "R6 ovf" : "R5 ovf", {63'b0, ovf}, {63'b0, model_ovf(exp, s)});
      check("R2 latency", 64'(n), 64'(LAT));
      check("R8 busy in done cycle", {63'b0, busy}, 64'd1);
      @(negedge clk);
      check("R2 done one cycle", {63'b0, done}, 64'd0);
      check("R8 busy low after done", {63'b0, busy}, 64'd0);
      if (disturb) check("R7 ignored start kept idle", {63'b0, busy}, 64'd0);
   endtask

   task automatic t_reset;
      check("R1 busy", {63'b0, busy}, 0);
      check("R1 done", {63'b0, done}, 0);
      check("R1 ovf",  {63'b0, ovf}, 0);
      check("R1 hi lo", {hi, lo}, 0);
   endtask

   task automatic t_unsigned;
      run_mul(32'd7, 32'd6, 1'b0, "R3", 1'b0);
      run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3", 1'b0);
      run_mul(32'h0001_0000, 32'h0001_0000, 1'b0, "R3", 1'b0);
      run_mul(32'h0000_FFFF, 32'h0001_0001, 1'b0, "R3", 1'b0);
      run_mul(32'd0, 32'hDEAD_BEEF, 1'b0, "R3", 1'b0);
      run_mul(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R3", 1'b0);
   endtask

   task automatic t_signed;
      run_mul(32'hFFFF_FFFF, 32'd1, 1'b1, "R4", 1'b0);
      run_mul(32'hFFFF_FFF9, 32'd6, 1'b1, "R4", 1'b0);
      run_mul(32'hFFFF_FFF9, 32'hFFFF_FFFA, 1'b1, "R4", 1'b0);
      run_mul(32'h8000_0000, 32'h8000_0000, 1'b1, "R4", 1'b0);
      run_mul(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R4", 1'b0);
      run_mul(32'h8000_0000, 32'd1, 1'b1, "R4", 1'b0);
      run_mul(32'h0001_0000, 32'hFFFF_8000, 1'b1, "R4", 1'b0);
      run_mul(32'h0001_0000, 32'hFFFF_7FFF, 1'b1, "R4", 1'b0);
   endtask

   task automatic t_busy_ignore;
      run_mul(32'h0BAD_F00D, 32'h0000_1357, 1'b0, "R7", 1'b1);
      run_mul(32'hF000_0001, 32'h0000_0003, 1'b1, "R7", 1'b1);
   endtask

   task automatic t_hold;
      logic [63:0] keep;
      logic        kov;
      keep = {hi, lo}; kov = ovf;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         op_a = 32'(i * 977); op_b = ~op_a; is_signed = i[0];
      end
      check("R9 hold hi lo", {hi, lo}, keep);
      check("R9 hold ovf", {63'b0, ovf}, {63'b0, kov});
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; is_signed = 1'b0; op_a = '0; op_b = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unsigned();
      t_signed();
      t_busy_ignore();
      t_hold();
      finished = 1'b1;
   end

   initial begin
      fork
         begin wait (finished); end
         begin
            repeat (20000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule